// File: doc/BRIEF.md
# Control-Slot Command Decoder

This block sits behind the serial port of a two-channel voice codec. It takes 16-bit control words picked out of the control slot of each frame and applies them to a bank of six 8-bit configuration registers per channel. A word either writes one channel's register, writes the same register in every channel at once (broadcast), or asks for a register's content. The answer to a read goes out in the next control slot, which is marked by the frame strobe. The serial shifter upstream delivers each word as a one-cycle strobe together with the channel the slot belongs to.

Writes go into a staging copy and reach the decoded configuration outputs only at a frame strobe. This keeps a new divider or port setting from changing in the middle of a frame. Register 1 of each channel also carries two sticky overflow flags. One-cycle event inputs from the converter filters set them, and reading that register clears them. Addresses 0 and 7 decode to no register.

Top module: `ctlword_decoder`

## Requirements
- R1: A command word is decoded as follows: bits 15..13 give the register address, bit 12 set means read and clear means write, bit 11 set means broadcast, bits 7..0 are the data, and bits 10..8 are ignored.
- R2: A non-broadcast write updates register `address` of the channel given by `cw_chan` and leaves every other channel unchanged.
- R3: A broadcast write updates the addressed register in all channels, whatever `cw_chan` is.
- R4: A written value appears on the configuration outputs at the first `frame_tick` that comes strictly after the cycle in which the word was accepted. A write accepted in the same cycle as a `frame_tick` waits for the following one. Between strobes the outputs hold.
- R5: A read captures the staged content of the addressed register of channel `cw_chan`. On the clock edge after the next `frame_tick`, `rd_valid` pulses for one cycle and `rd_data` = {address[2:0], 1, 0, 000, content[7:0]}. `rd_data` holds its value until the next response.
- R6: Addresses 0 and 7 are undefined. Writes to them change nothing, and reads of them return content 0.
- R7: In register 1, bit 7 (converter-input overflow) and bit 4 (converter-output overflow) are read-only. Written values for those two bits are discarded, and the other six bits of register 1 are stored as written.
- R8: An overflow flag is set by a one-cycle event input and stays set until register 1 of that channel is read. That read returns the flag values from before the clear. If an event arrives in the same cycle as the clearing read, the flag stays set. Flags show on the configuration outputs without waiting for a frame strobe.
- R9: After reset every register, flag, `rd_valid` and `rd_data` is 0.
- R10: `cfg_bus` bits [(c*6 + a-1)*8 +: 8] carry the active value of register a (1..6) of channel c. `gpo[c]` is register 2 bit 2. `host_sel[2c+1:2c]` is register 2 bits 1..0, where 00 and 01 pick the two serial host-port protocols. `div_mnp[7c+6:7c]` is register 4 bits 6..0, the M/N/P divider field behind FS = MCLK/(16·M·N·P).
- R11: A `frame_tick` with no read pending leaves `rd_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_valid | input | 1 | One-cycle strobe: `cw_word` holds a control word |
| cw_word | input | 16 | Control word from the control slot |
| cw_chan | input | CH_W (1) | Channel the control slot belongs to |
| frame_tick | input | 1 | One-cycle frame strobe |
| adc_ovf_evt | input | NCH (2) | Per-channel converter-input overflow event |
| dac_ovf_evt | input | NCH (2) | Per-channel converter-output overflow event |
| rd_valid | output | 1 | One-cycle pulse: read response ready |
| rd_data | output | 16 | Read response word |
| cfg_bus | output | NCH*6*8 (96) | Active register bytes, all channels |
| gpo | output | NCH (2) | General-purpose output per channel |
| host_sel | output | 2*NCH (4) | Host-port protocol select per channel |
| div_mnp | output | 7*NCH (14) | Frame-rate divider field per channel |

## Verification
The assertions assume that `frame_tick` pulses last one cycle and that two pulses are at least two cycles apart. This is what makes the one-cycle shape of `rd_valid` and the hold of the active registers meaningful. They also assume that `cw_chan` names an existing channel and that event inputs are single-cycle. The bench drives each word and each strobe for exactly one cycle, with idle cycles between strobes. It only places a word in the same cycle as a strobe in the one directed test that targets that ordering.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  localparam int WORD_W   = 16;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int NUM_REGS = 6;
  localparam int NUM_CH   = 2;
  localparam int ADC_FLAG_BIT = 7;
  localparam int DAC_FLAG_BIT = 4;
  localparam int DIV_W    = 7;
  localparam int HOST_W   = 2;
  localparam int GPO_BIT  = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              bcast;
    logic [2:0]        spare;
    logic [DATA_W-1:0] data;
  } ctl_word_t;
endpackage

// File: rtl/cw_parse.sv
module cw_parse
  import cwd_pkg::*;
#(
  parameter int NCH   = NUM_CH,
  parameter int CH_W  = 1,
  parameter int NREG  = NUM_REGS,
  parameter int IDX_W = 3
) (
  input  logic              cw_valid,
  input  logic [WORD_W-1:0] cw_word,
  input  logic [CH_W-1:0]   cw_chan,
  output logic [NCH-1:0]    wr_en,
  output logic              rd_en,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              idx_ok,
  output logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr
);
  ctl_word_t w;
  assign w       = ctl_word_t'(cw_word);
  assign addr    = w.addr;
  assign wdata   = w.data;
  assign idx_ok  = (int'(w.addr) >= 1) && (int'(w.addr) <= NREG);
  assign reg_idx = IDX_W'(w.addr - ADDR_W'(1));
  assign rd_en   = cw_valid && w.rd;

  always_comb begin
    wr_en = '0;
    if (cw_valid && !w.rd && idx_ok) begin
      for (int c = 0; c < NCH; c++) begin
        if (w.bcast || (int'(cw_chan) == c)) wr_en[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/chan_regbank.sv
module chan_regbank
  import cwd_pkg::*;
#(
  parameter int NREG  = NUM_REGS,
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   frame_tick,
  input  logic                   adc_evt,
  input  logic                   dac_evt,
  input  logic                   flag_clr,
  output logic [NREG*DATA_W-1:0] stage_bus,
  output logic [NREG*DATA_W-1:0] active_bus
);
  localparam logic [DATA_W-1:0] RO_MASK =
    DATA_W'((1 << ADC_FLAG_BIT) | (1 << DAC_FLAG_BIT));

  logic [DATA_W-1:0] shadow [NREG];
  logic [DATA_W-1:0] active [NREG];
  logic              adc_flag, dac_flag;
  logic [NREG*DATA_W-1:0] active_pk;
  logic [DATA_W-1:0] flag_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end
      adc_flag <= 1'b0;
      dac_flag <= 1'b0;
    end else begin
      if (frame_tick) begin
        for (int i = 0; i < NREG; i++) active[i] <= shadow[i];
      end
      if (wr_en) begin
        shadow[wr_idx] <= (wr_idx == '0) ? (wr_data & ~RO_MASK) : wr_data;
      end
      adc_flag <= adc_evt | (adc_flag & ~flag_clr);
      dac_flag <= dac_evt | (dac_flag & ~flag_clr);
    end
  end

  always_comb begin
    flag_byte = '0;
    flag_byte[ADC_FLAG_BIT] = adc_flag;
    flag_byte[DAC_FLAG_BIT] = dac_flag;
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_pack
      if (g == 0) begin : g_flags
        assign stage_bus[g*DATA_W +: DATA_W]  = shadow[g] | flag_byte;
        assign active_bus[g*DATA_W +: DATA_W] = active[g] | flag_byte;
      end else begin : g_plain
        assign stage_bus[g*DATA_W +: DATA_W]  = shadow[g];
        assign active_bus[g*DATA_W +: DATA_W] = active[g];
      end
      assign active_pk[g*DATA_W +: DATA_W] = active[g];
    end
  endgenerate

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(active_pk)); // R4
  AST_ADC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    adc_evt |=> adc_flag); // R8
  AST_ADC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_flag && !flag_clr) |=> adc_flag); // R8
  AST_DAC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_flag && !dac_evt) |=> !dac_flag); // R7
endmodule

// File: rtl/rsp_unit.sv
module rsp_unit
  import cwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_content,
  input  logic              frame_tick,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  logic              pending;
  logic [WORD_W-1:0] hold;
  ctl_word_t         rsp;

  always_comb begin
    rsp       = '0;
    rsp.addr  = rd_addr;
    rsp.rd    = 1'b1;
    rsp.data  = rd_content;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      hold     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= frame_tick & pending;
      if (frame_tick && pending) rd_data <= hold;
      if (rd_en) begin
        pending <= 1'b1;
        hold    <= rsp;
      end else if (frame_tick) begin
        pending <= 1'b0;
      end
    end
  end

  AST_RDV_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(frame_tick)); // R5
  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R5
  AST_RDV_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data)); // R5
endmodule

// File: rtl/ctlword_decoder.sv
module ctlword_decoder
  import cwd_pkg::*;
#(
  parameter int NCH  = NUM_CH,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cw_valid,
  input  logic [WORD_W-1:0]             cw_word,
  input  logic [CH_W-1:0]               cw_chan,
  input  logic                          frame_tick,
  input  logic [NCH-1:0]                adc_ovf_evt,
  input  logic [NCH-1:0]                dac_ovf_evt,
  output logic                          rd_valid,
  output logic [WORD_W-1:0]             rd_data,
  output logic [NCH*NUM_REGS*DATA_W-1:0] cfg_bus,
  output logic [NCH-1:0]                gpo,
  output logic [HOST_W*NCH-1:0]         host_sel,
  output logic [DIV_W*NCH-1:0]          div_mnp
);
  localparam int NREG   = NUM_REGS;
  localparam int IDX_W  = $clog2(NREG);
  localparam int BANK_W = NREG * DATA_W;
  localparam int REG2_LO = 1 * DATA_W;
  localparam int REG4_LO = 3 * DATA_W;

  logic [NCH-1:0]    wr_en;
  logic              rd_en;
  logic [IDX_W-1:0]  reg_idx;
  logic              idx_ok;
  logic [DATA_W-1:0] wdata;
  logic [ADDR_W-1:0] addr;
  logic [BANK_W-1:0] stage_all [NCH];
  logic [DATA_W-1:0] rd_content;
  logic              chan_ok;

  cw_parse #(.NCH(NCH), .CH_W(CH_W), .NREG(NREG), .IDX_W(IDX_W)) u_parse (
    .cw_valid (cw_valid),
    .cw_word  (cw_word),
    .cw_chan  (cw_chan),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .reg_idx  (reg_idx),
    .idx_ok   (idx_ok),
    .wdata    (wdata),
    .addr     (addr)
  );

  assign chan_ok = int'(cw_chan) < NCH;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [BANK_W-1:0] act;
      logic              clr;
      assign clr = rd_en && (int'(addr) == 1) && (int'(cw_chan) == c);

      chan_regbank #(.NREG(NREG), .IDX_W(IDX_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en[c]),
        .wr_idx     (reg_idx),
        .wr_data    (wdata),
        .frame_tick (frame_tick),
        .adc_evt    (adc_ovf_evt[c]),
        .dac_evt    (dac_ovf_evt[c]),
        .flag_clr   (clr),
        .stage_bus  (stage_all[c]),
        .active_bus (act)
      );

      assign cfg_bus[c*BANK_W +: BANK_W]     = act;
      assign gpo[c]                          = act[REG2_LO + GPO_BIT];
      assign host_sel[c*HOST_W +: HOST_W]    = act[REG2_LO +: HOST_W];
      assign div_mnp[c*DIV_W +: DIV_W]       = act[REG4_LO +: DIV_W];
    end
  endgenerate

  always_comb begin
    rd_content = '0;
    if (idx_ok && chan_ok) begin
      for (int c = 0; c < NCH; c++) begin
        if (int'(cw_chan) == c) rd_content = stage_all[c][reg_idx*DATA_W +: DATA_W];
      end
    end
  end

  rsp_unit u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_addr    (addr),
    .rd_content (rd_content),
    .frame_tick (frame_tick),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && (rd_data[15:13] == 3'd0 || rd_data[15:13] == 3'd7))
      |-> (rd_data[7:0] == 8'h00)); // R6
  AST_RSP_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[12] && rd_data[11:8] == 4'h0)); // R5
endmodule

// File: tb/ctlword_decoder_test.sv
`timescale 1ns/1ps
module ctlword_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cw_valid = 1'b0;
  logic [15:0] cw_word = '0;
  logic [0:0]  cw_chan = '0;
  logic        frame_tick = 1'b0;
  logic [1:0]  adc_ovf_evt = '0;
  logic [1:0]  dac_ovf_evt = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [95:0] cfg_bus;
  logic [1:0]  gpo;
  logic [3:0]  host_sel;
  logic [13:0] div_mnp;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ctlword_decoder uut (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_word(cw_word),
    .cw_chan(cw_chan), .frame_tick(frame_tick), .adc_ovf_evt(adc_ovf_evt),
    .dac_ovf_evt(dac_ovf_evt), .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_bus(cfg_bus), .gpo(gpo), .host_sel(host_sel), .div_mnp(div_mnp)
  );

  // {is_read, chan, word, expected}: expected is the active byte for writes
  // and the full response word for reads.
  localparam logic [33:0] VEC [12] = '{
    {1'b0, 1'b0, 16'h4005, 16'h0005},  // R2 write reg2 ch0
    {1'b1, 1'b0, 16'h5000, 16'h5005},  // R5 read reg2 ch0
    {1'b0, 1'b1, 16'h883A, 16'h003A},  // R3 broadcast reg4
    {1'b1, 1'b0, 16'h9000, 16'h903A},  // R3 other channel also got it
    {1'b0, 1'b1, 16'h20FF, 16'h006F},  // R7 flag bits discarded
    {1'b1, 1'b1, 16'h3000, 16'h306F},  // R7 read back
    {1'b0, 1'b1, 16'hC081, 16'h0081},  // R2 write reg6 ch1
    {1'b1, 1'b0, 16'hD000, 16'hD000},  // R2 ch0 reg6 untouched
    {1'b1, 1'b1, 16'hD000, 16'hD081},  // R5 read reg6 ch1
    {1'b1, 1'b0, 16'h1000, 16'h1000},  // R6 read address 0
    {1'b0, 1'b1, 16'h4705, 16'h0005},  // R1 spare bits ignored
    {1'b1, 1'b1, 16'h5700, 16'h5005}   // R1 spare bits not echoed
  };

  task automatic check(input bit ok, input string tag, input logic [95:0] act,
                       input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input logic [0:0] ch);
    @(negedge clk);
    cw_valid = 1'b1; cw_word = w; cw_chan = ch;
    @(negedge clk);
    cw_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  function automatic logic [7:0] reg_byte(input int c, input int a);
    return cfg_bus[(c*6 + a - 1)*8 +: 8];
  endfunction

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [95:0] saved;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(cfg_bus == '0, "R9 cfg_bus", cfg_bus, 96'h0);
    check(!rd_valid && rd_data == 16'h0, "R9 read port", {rd_valid, rd_data}, 0);
    // R11 strobe with nothing pending
    tick();
    check(rd_valid == 1'b0, "R11 idle strobe", rd_valid, 0);

    for (int i = 0; i < 12; i++) begin
      logic        is_rd;
      logic [0:0]  ch;
      logic [15:0] w, e;
      {is_rd, ch, w, e} = VEC[i];
      send(w, ch);
      tick();
      if (is_rd) begin
        check(rd_valid && rd_data == e, $sformatf("R5 vec%0d", i), rd_data, e);
      end else begin
        check(reg_byte(int'(ch), int'(w[15:13])) == e[7:0],
              $sformatf("R2 vec%0d", i), reg_byte(int'(ch), int'(w[15:13])), e);
      end
    end

    // R10 decoded fields
    check(div_mnp == {7'h3A, 7'h3A}, "R10 divider", div_mnp, {7'h3A, 7'h3A});
    check(gpo[0] && host_sel[1:0] == 2'b01, "R10 reg2 fields", {gpo, host_sel}, 6'h05);

    // R4 staging
    send(16'h4002, 1'b0);
    check(gpo[0] == 1'b1, "R4 hold before strobe", gpo[0], 1);
    tick();
    check(!gpo[0] && host_sel[1:0] == 2'b10, "R4 applied at strobe",
          {gpo[0], host_sel[1:0]}, 3'b010);
    @(negedge clk);
    cw_valid = 1'b1; cw_word = 16'h4007; cw_chan = 1'b0; frame_tick = 1'b1;
    @(negedge clk);
    cw_valid = 1'b0; frame_tick = 1'b0;
    check(host_sel[1:0] == 2'b10, "R4 same-cycle write waits", host_sel[1:0], 2);
    tick();
    check(gpo[0] && host_sel[1:0] == 2'b11, "R4 next strobe",
          {gpo[0], host_sel[1:0]}, 3'b111);

    // R6 undefined writes
    saved = cfg_bus;
    send(16'hE0AA, 1'b0);
    send(16'h00AA, 1'b1);
    tick();
    check(cfg_bus == saved, "R6 undefined write", cfg_bus, saved);
    send(16'hF000, 1'b0);
    tick();
    check(rd_valid && rd_data == 16'hF000, "R6 read address 7", rd_data, 16'hF000);

    // R7 flag bits not writable
    send(16'h2090, 1'b0);
    tick();
    send(16'h3000, 1'b0);
    tick();
    check(rd_data == 16'h3000, "R7 write to flags", rd_data, 16'h3000);

    // R8 sticky flags
    @(negedge clk); adc_ovf_evt = 2'b01;
    @(negedge clk); adc_ovf_evt = 2'b00;
    check(cfg_bus[7] == 1'b1, "R8 live flag", cfg_bus[7], 1);
    send(16'h3000, 1'b0);
    tick();
    check(rd_data == 16'h3080, "R8 flag read", rd_data, 16'h3080);
    send(16'h3000, 1'b0);
    tick();
    check(rd_data == 16'h3000, "R8 cleared by read", rd_data, 16'h3000);
    @(negedge clk);
    cw_valid = 1'b1; cw_word = 16'h3000; cw_chan = 1'b0; adc_ovf_evt = 2'b01;
    @(negedge clk);
    cw_valid = 1'b0; adc_ovf_evt = 2'b00;
    tick();
    check(rd_data == 16'h3000, "R8 read before set", rd_data, 16'h3000);
    send(16'h3000, 1'b0);
    tick();
    check(rd_data == 16'h3080, "R8 event wins over clear", rd_data, 16'h3080);
    @(negedge clk); dac_ovf_evt = 2'b10;
    @(negedge clk); dac_ovf_evt = 2'b00;
    send(16'h3000, 1'b1);
    tick();
    check(rd_data == 16'h307F, "R8 other flag ch1", rd_data, 16'h307F);
    check(reg_byte(0, 1)[4] == 1'b0, "R8 ch0 flag untouched", reg_byte(0, 1), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule